// File: doc/BRIEF.md
# Lazy Writeback Dirty Chunk Tracker

This block keeps the dirty state of a software-managed local memory at the granularity of 64-byte chunks, so that modified data goes back to the global memory system only when its storage is reclaimed. Each chunk holds one dirty flag and the index of the address mapping that the store which first dirtied it used. Each mapping holds a count of how many chunks it currently owns in the dirty state.

A store miss marks a clean chunk dirty, records its mapping and bumps that mapping's count. An eviction request for a dirty chunk raises a writeback request that carries the chunk number and its recorded mapping, so that a downstream unit can form the physical address. The chunk is cleared and the mapping's count is lowered only once the downstream side accepts the request. No flush takes place at synchronization points: dirty data stays put until an eviction asks for the room. A per-mapping flag shows when a mapping owns no dirty chunks and may therefore be released.

Top module: `dirty_chunk_tracker`

## Requirements
- R1: After reset every chunk is clean, every mapping count reads 0, every bit of `map_free` is 1, `wb_valid` is 0 and `ev_ready` is 1.
- R2: A store event (`st_valid`=1) to a clean chunk makes it dirty, records `st_map` as its mapping, and raises that mapping's count by 1, visible on `cnt_value` from the cycle after the event.
- R3: A store event to a chunk that is already dirty changes no count and leaves the recorded mapping as it was; a later writeback of that chunk carries the first mapping.
- R4: An accepted eviction (`ev_valid`=1 and `ev_ready`=1) of a dirty chunk sets `wb_valid` to 1 in the next cycle, with `wb_chunk` equal to the evicted chunk and `wb_map` equal to its recorded mapping.
- R5: An accepted eviction of a clean chunk raises no writeback and leaves every count unchanged.
- R6: While `wb_valid` is 1 and `wb_ready` is 0, `wb_valid`, `wb_chunk` and `wb_map` hold their values; `ev_ready` is 0 whenever `wb_valid` is 1, and an eviction offered then has no effect.
- R7: In a cycle with `wb_valid`=1 and `wb_ready`=1 the request is taken: from the next cycle `wb_valid` is 0, the chunk is clean (evicting it again raises no writeback) and the mapping's count is 1 lower.
- R8: `map_free[m]` is 1 exactly when the count of mapping m is 0.
- R9: With no eviction, dirty chunks stay dirty and no writeback is raised however long the block sits idle.
- R10: A store that dirties a chunk under mapping m in the same cycle that a writeback of mapping m is taken leaves the count of m unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store-miss event strobe |
| st_chunk | input | CHUNK_W | Chunk written by the store |
| st_map | input | MAP_W | Mapping used by the store |
| ev_valid | input | 1 | Eviction request strobe |
| ev_chunk | input | CHUNK_W | Chunk to be evicted |
| ev_ready | output | 1 | Eviction request can be taken this cycle |
| wb_valid | output | 1 | Writeback request pending |
| wb_ready | input | 1 | Downstream takes the writeback request |
| wb_chunk | output | CHUNK_W | Chunk to write back |
| wb_map | output | MAP_W | Mapping for address generation |
| cnt_sel | input | MAP_W | Mapping whose count is read out |
| cnt_value | output | CNT_W | Dirty-chunk count of the selected mapping |
| map_free | output | NUM_MAPS | Per-mapping flag: count is zero |

## Verification
Directed sequences first take one chunk through its full life: a first store, a second store under another mapping, a clean eviction, a dirty eviction held by back-pressure, a long idle stretch and a final acceptance with a re-eviction. This separates a mapping index that is overwritten from one that sticks, a writeback that ignores the dirty flag from one that honours it, and a chunk cleared on launch from one cleared on acceptance. A directed case lines up a store and a taken writeback on the same mapping to tell a lost increment or decrement from a correct net zero. Seeded random traffic with random back-pressure then mixes stores, evictions and readout selections, so that colliding chunks, repeated mappings and evictions offered while a request is pending are all compared against a bench model.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Classification of an eviction request in the cycle it is offered.
  typedef enum logic [1:0] {
    EVK_NONE  = 2'd0,
    EVK_CLEAN = 2'd1,
    EVK_DIRTY = 2'd2
  } evict_kind_e;

  // Index width for a population of n items, never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of a counter that must reach the value n.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dct_chunk_state.sv
module dct_chunk_state #(
  parameter int NUM_CHUNKS = 16,
  parameter int NUM_MAPS   = 4,
  localparam int CHUNK_W   = dct_pkg::idx_width(NUM_CHUNKS),
  localparam int MAP_W     = dct_pkg::idx_width(NUM_MAPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic [CHUNK_W-1:0]          set_chunk,
  input  logic [MAP_W-1:0]            set_map,
  input  logic                        clr_en,
  input  logic [CHUNK_W-1:0]          clr_chunk,
  output logic [NUM_CHUNKS-1:0]       dirty_vec,
  output logic [NUM_CHUNKS*MAP_W-1:0] map_flat
);

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    logic             hit_set;
    logic             hit_clr;
    logic             dirty_q;
    logic [MAP_W-1:0] map_q;

    assign hit_set = set_en && (set_chunk == CHUNK_W'(g));
    assign hit_clr = clr_en && (clr_chunk == CHUNK_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirty_q <= 1'b0;
        map_q   <= '0;
      end else if (hit_set) begin
        dirty_q <= 1'b1;
        map_q   <= set_map;
      end else if (hit_clr) begin
        dirty_q <= 1'b0;
      end
    end

    assign dirty_vec[g]                 = dirty_q;
    assign map_flat[g*MAP_W +: MAP_W]   = map_q;
  end

endmodule

// File: rtl/dct_map_counters.sv
module dct_map_counters #(
  parameter int NUM_MAPS   = 4,
  parameter int NUM_CHUNKS = 16,
  localparam int MAP_W     = dct_pkg::idx_width(NUM_MAPS),
  localparam int CNT_W     = dct_pkg::count_width(NUM_CHUNKS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inc_en,
  input  logic [MAP_W-1:0]          inc_map,
  input  logic                      dec_en,
  input  logic [MAP_W-1:0]          dec_map,
  output logic [NUM_MAPS*CNT_W-1:0] count_flat,
  output logic [NUM_MAPS-1:0]       free_vec
);

  // Next count from the present one and the two event strobes.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             up,
    input logic             down
  );
    if (up && !down)      return cur + CNT_W'(1);
    else if (down && !up) return cur - CNT_W'(1);
    else                  return cur;
  endfunction

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    logic             up;
    logic             down;
    logic [CNT_W-1:0] cnt_q;

    assign up   = inc_en && (inc_map == MAP_W'(g));
    assign down = dec_en && (dec_map == MAP_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= next_count(cnt_q, up, down);
    end

    assign count_flat[g*CNT_W +: CNT_W] = cnt_q;
    assign free_vec[g]                  = (cnt_q == '0);
  end

endmodule

// File: rtl/dct_wb_slot.sv
module dct_wb_slot #(
  parameter int CHUNK_W = 4,
  parameter int MAP_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [CHUNK_W-1:0] load_chunk,
  input  logic [MAP_W-1:0]   load_map,
  input  logic               wb_ready,
  output logic               wb_valid,
  output logic [CHUNK_W-1:0] wb_chunk,
  output logic [MAP_W-1:0]   wb_map,
  output logic               accept
);

  assign accept = wb_valid && wb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_chunk <= '0;
      wb_map   <= '0;
    end else if (load_en) begin
      wb_valid <= 1'b1;
      wb_chunk <= load_chunk;
      wb_map   <= load_map;
    end else if (accept) begin
      wb_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dirty_chunk_tracker.sv
module dirty_chunk_tracker #(
  parameter int NUM_CHUNKS = 16,
  parameter int NUM_MAPS   = 4,
  localparam int CHUNK_W   = dct_pkg::idx_width(NUM_CHUNKS),
  localparam int MAP_W     = dct_pkg::idx_width(NUM_MAPS),
  localparam int CNT_W     = dct_pkg::count_width(NUM_CHUNKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [CHUNK_W-1:0]  st_chunk,
  input  logic [MAP_W-1:0]    st_map,
  input  logic                ev_valid,
  input  logic [CHUNK_W-1:0]  ev_chunk,
  output logic                ev_ready,
  output logic                wb_valid,
  input  logic                wb_ready,
  output logic [CHUNK_W-1:0]  wb_chunk,
  output logic [MAP_W-1:0]    wb_map,
  input  logic [MAP_W-1:0]    cnt_sel,
  output logic [CNT_W-1:0]    cnt_value,
  output logic [NUM_MAPS-1:0] map_free
);
  import dct_pkg::*;

  logic [NUM_CHUNKS-1:0]       dirty_vec;
  logic [NUM_CHUNKS*MAP_W-1:0] map_flat;
  logic [NUM_MAPS*CNT_W-1:0]   count_flat;

  // Named internal events, also used by the checker.
  logic        st_set;
  logic        ev_fire;
  logic        wb_launch;
  logic        wb_accept;
  evict_kind_e ev_kind;
  logic [MAP_W-1:0] ev_map;

  function automatic logic [MAP_W-1:0] map_of(
    input logic [NUM_CHUNKS*MAP_W-1:0] flat,
    input logic [CHUNK_W-1:0]          idx
  );
    return flat[int'(idx)*MAP_W +: MAP_W];
  endfunction

  function automatic logic [CNT_W-1:0] count_of(
    input logic [NUM_MAPS*CNT_W-1:0] flat,
    input logic [MAP_W-1:0]          idx
  );
    return flat[int'(idx)*CNT_W +: CNT_W];
  endfunction

  assign ev_ready = !wb_valid;
  assign ev_fire  = ev_valid && ev_ready;
  assign st_set   = st_valid && !dirty_vec[st_chunk];
  assign ev_map   = map_of(map_flat, ev_chunk);

  always_comb begin
    if (!ev_fire)                 ev_kind = EVK_NONE;
    else if (dirty_vec[ev_chunk]) ev_kind = EVK_DIRTY;
    else                          ev_kind = EVK_CLEAN;
  end

  assign wb_launch = (ev_kind == EVK_DIRTY);

  dct_chunk_state #(
    .NUM_CHUNKS(NUM_CHUNKS),
    .NUM_MAPS  (NUM_MAPS)
  ) u_chunks (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (st_set),
    .set_chunk(st_chunk),
    .set_map  (st_map),
    .clr_en   (wb_accept),
    .clr_chunk(wb_chunk),
    .dirty_vec(dirty_vec),
    .map_flat (map_flat)
  );

  dct_map_counters #(
    .NUM_MAPS  (NUM_MAPS),
    .NUM_CHUNKS(NUM_CHUNKS)
  ) u_counts (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_en    (st_set),
    .inc_map   (st_map),
    .dec_en    (wb_accept),
    .dec_map   (wb_map),
    .count_flat(count_flat),
    .free_vec  (map_free)
  );

  dct_wb_slot #(
    .CHUNK_W(CHUNK_W),
    .MAP_W  (MAP_W)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (wb_launch),
    .load_chunk(ev_chunk),
    .load_map  (ev_map),
    .wb_ready  (wb_ready),
    .wb_valid  (wb_valid),
    .wb_chunk  (wb_chunk),
    .wb_map    (wb_map),
    .accept    (wb_accept)
  );

  assign cnt_value = count_of(count_flat, cnt_sel);

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int NUM_CHUNKS = 16,
  parameter int NUM_MAPS   = 4,
  localparam int CHUNK_W   = dct_pkg::idx_width(NUM_CHUNKS),
  localparam int MAP_W     = dct_pkg::idx_width(NUM_MAPS),
  localparam int CNT_W     = dct_pkg::count_width(NUM_CHUNKS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ev_fire,
  input logic [CHUNK_W-1:0]        ev_chunk,
  input logic                      ev_ready,
  input logic [NUM_CHUNKS-1:0]     dirty_vec,
  input logic [NUM_MAPS*CNT_W-1:0] count_flat,
  input logic                      wb_valid,
  input logic                      wb_ready,
  input logic                      wb_accept,
  input logic [CHUNK_W-1:0]        wb_chunk,
  input logic [MAP_W-1:0]          wb_map
);

  int total_cnt;
  always_comb begin
    total_cnt = 0;
    for (int i = 0; i < NUM_MAPS; i++) total_cnt += int'(count_flat[i*CNT_W +: CNT_W]);
  end

  // R2 / R7: the counts always add up to the number of dirty chunks.
  p_sum_matches_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    total_cnt == $countones(dirty_vec));

  p_dirty_evict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && dirty_vec[ev_chunk]) |=> (wb_valid && wb_chunk == $past(ev_chunk)));

  p_clean_evict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !dirty_vec[ev_chunk]) |=> !wb_valid);

  p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_chunk) && $stable(wb_map)));

  p_no_evict_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !ev_ready);

  p_clear_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_accept |=> (!wb_valid && !dirty_vec[$past(wb_chunk)]));

endmodule

bind dirty_chunk_tracker dct_checker #(
  .NUM_CHUNKS(NUM_CHUNKS),
  .NUM_MAPS  (NUM_MAPS)
) u_dct_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_fire   (ev_fire),
  .ev_chunk  (ev_chunk),
  .ev_ready  (ev_ready),
  .dirty_vec (dirty_vec),
  .count_flat(count_flat),
  .wb_valid  (wb_valid),
  .wb_ready  (wb_ready),
  .wb_accept (wb_accept),
  .wb_chunk  (wb_chunk),
  .wb_map    (wb_map)
);

// File: tb/tb_dirty_chunk_tracker.sv
`timescale 1ns/1ps
module tb_dirty_chunk_tracker;
  localparam int NC      = 16;
  localparam int NM      = 4;
  localparam int CW      = 4;
  localparam int MW      = 2;
  localparam int KW      = 5;
  localparam int WATCHDOG_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [CW-1:0] st_chunk = '0;
  logic [MW-1:0] st_map = '0;
  logic          ev_valid = 1'b0;
  logic [CW-1:0] ev_chunk = '0;
  logic          ev_ready;
  logic          wb_valid;
  logic          wb_ready = 1'b0;
  logic [CW-1:0] wb_chunk;
  logic [MW-1:0] wb_map;
  logic [MW-1:0] cnt_sel = '0;
  logic [KW-1:0] cnt_value;
  logic [NM-1:0] map_free;

  always #2.5 clk = ~clk;

  dirty_chunk_tracker #(.NUM_CHUNKS(NC), .NUM_MAPS(NM)) dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_chunk(st_chunk), .st_map(st_map),
    .ev_valid(ev_valid), .ev_chunk(ev_chunk), .ev_ready(ev_ready),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_chunk(wb_chunk), .wb_map(wb_map),
    .cnt_sel(cnt_sel), .cnt_value(cnt_value), .map_free(map_free)
  );

  // Bench model of the requirements.
  bit m_dirty [NC];
  int m_map   [NC];
  int m_cnt   [NM];
  bit m_wbv;
  int m_wbc, m_wbm;

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NC; i++) begin m_dirty[i] = 0; m_map[i] = 0; end
    for (int i = 0; i < NM; i++) m_cnt[i] = 0;
    m_wbv = 0; m_wbc = 0; m_wbm = 0;
  endfunction

  // Applies one clock of the rules to the model, using pre-edge state.
  function automatic void model_step();
    bit take, fire, set, launch;
    int lc, lm;
    take   = m_wbv && wb_ready;
    fire   = ev_valid && !m_wbv;
    set    = st_valid && !m_dirty[st_chunk];
    launch = fire && m_dirty[ev_chunk];
    lc = int'(ev_chunk);
    lm = m_map[ev_chunk];
    if (take) begin
      m_dirty[m_wbc] = 0;
      m_cnt[m_wbm]--;
      m_wbv = 0;
    end
    if (set) begin
      m_dirty[st_chunk] = 1;
      m_map[st_chunk] = int'(st_map);
      m_cnt[st_map]++;
    end
    if (launch) begin
      m_wbv = 1; m_wbc = lc; m_wbm = lm;
    end
  endfunction

  // Inputs are set just after a falling edge; one rising edge is applied.
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check(req, "wb_valid", int'(wb_valid), int'(m_wbv));
    check(req, "ev_ready", int'(ev_ready), int'(!m_wbv));
    if (m_wbv) begin
      check(req, "wb_chunk", int'(wb_chunk), m_wbc);
      check(req, "wb_map", int'(wb_map), m_wbm);
    end
    for (int m = 0; m < NM; m++) begin
      cnt_sel = MW'(m);
      #0.2;
      check(req, "cnt_value", int'(cnt_value), m_cnt[m]);
      check("R8", "map_free", int'(map_free[m]), int'(m_cnt[m] == 0));
    end
  endtask

  task automatic idle_inputs();
    st_valid = 1'b0; ev_valid = 1'b0;
  endtask

  initial begin
    #(WATCHDOG_CYCLES * 5.0);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_all("R1");
    check("R1", "map_free all", int'(map_free), (1 << NM) - 1);

    // R2: store to clean chunk 3 with mapping 2
    st_valid = 1; st_chunk = 4'd3; st_map = 2'd2;
    step(); idle_inputs();
    check_all("R2");

    // R3: second store to chunk 3 with mapping 1 has no effect
    st_valid = 1; st_chunk = 4'd3; st_map = 2'd1;
    step(); idle_inputs();
    check_all("R3");

    // R5: evict clean chunk 5
    ev_valid = 1; ev_chunk = 4'd5;
    step(); idle_inputs();
    check_all("R5");

    // R4 / R3: evict dirty chunk 3 under back-pressure; mapping stays 2
    ev_valid = 1; ev_chunk = 4'd3;
    step(); idle_inputs();
    check_all("R4");
    check("R3", "wb_map first mapping", int'(wb_map), 2);

    // R6: hold while not ready; a second eviction of chunk 7 is refused
    st_valid = 1; st_chunk = 4'd7; st_map = 2'd1;
    step(); idle_inputs();
    for (int k = 0; k < 4; k++) begin
      ev_valid = 1; ev_chunk = 4'd7;
      step();
      check_all("R6");
      check("R6", "wb_chunk held", int'(wb_chunk), 3);
    end
    idle_inputs();

    // R9: long idle, nothing written back, counts stay
    repeat (50) step();
    check_all("R9");

    // R7: accept, then re-evict chunk 3
    wb_ready = 1;
    step();
    wb_ready = 0;
    check_all("R7");
    check("R7", "wb_valid dropped", int'(wb_valid), 0);
    ev_valid = 1; ev_chunk = 4'd3;
    step(); idle_inputs();
    check_all("R7");
    check("R7", "no writeback for cleaned chunk", int'(wb_valid), 0);

    // R10: store under mapping 1 while writeback of mapping 1 is taken
    ev_valid = 1; ev_chunk = 4'd7;
    step(); idle_inputs();
    check_all("R4");
    st_valid = 1; st_chunk = 4'd9; st_map = 2'd1; wb_ready = 1;
    step(); idle_inputs(); wb_ready = 0;
    check_all("R10");
    cnt_sel = 2'd1; #0.2;
    check("R10", "mapping 1 count", int'(cnt_value), 1);

    // Seeded random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      st_valid = ($urandom_range(99, 0) < 45);
      st_chunk = CW'($urandom_range(NC - 1, 0));
      st_map   = MW'($urandom_range(NM - 1, 0));
      ev_valid = ($urandom_range(99, 0) < 35);
      ev_chunk = CW'($urandom_range(NC - 1, 0));
      wb_ready = ($urandom_range(99, 0) < 50);
      step();
      if (m_wbv) check_all("R6");
      else       check_all("R2");
    end
    idle_inputs(); wb_ready = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule